// File: doc/BRIEF.md
# Timebase Divider with Rate Tap and Update Sequencer

This block turns a 32.768 kHz enable tick into the slower timing signals a calendar clock needs. A fifteen-stage binary chain counts the ticks. A four-bit rate code picks one of thirteen chain stages (or none), and that stage drives both a gated square-wave output and a one-cycle periodic pulse taken on each rising edge of the stage.

The same chain paces the once-per-second update. A status bit goes high eight ticks (about 244 µs) before each update strobe and stays high through the strobe, so software that sees it low knows it has at least that long before the time registers change. A hold input stops transfers and drops the status bit. A three-bit oscillator code runs the chain, freezes it, or pins it at zero. When it is released from zero, the first update comes half a second later.

Top module: `rtc_divider_timing`

## Requirements
- R1: While porN is low, and in the first cycle after it rises, sqwOut, periodicPulse, uipFlag, updateStrobe and updateDone are all 0, and the chain stands at phase zero.
- R2: Selected stage frequency for rate codes 1 to 7: 1 gives 256 Hz, 2 gives 128 Hz, 3 gives 8192 Hz, 4 gives 4096 Hz, 5 gives 2048 Hz, 6 gives 1024 Hz and 7 gives 512 Hz. Each is a square wave counted in ticks from phase zero, starting low.
- R3: Rate codes 8 to 15 give 256, 128, 64, 32, 16, 8, 4 and 2 Hz in that order. Code 0 selects a constant low stage, so no periodic pulse occurs.
- R4: sqwOut equals the selected stage while sqwEn is 1 and is 0 while sqwEn is 0.
- R5: periodicPulse is high for exactly one cycle, in the cycle after the selected stage goes from 0 to 1. It does not depend on sqwEn.
- R6: oscCtl 3'b010 advances the chain by one on each cycle with tick high. oscCtl 3'b110 or 3'b111 forces the chain to zero. Every other code freezes the chain and ignores tick. Any code other than 3'b010 clears uipFlag.
- R7: The chain starts at zero. An update strobe is produced when the tick moves the chain phase to 16384, so the first update follows 16384 ticks after release and later ones follow every 32768 ticks.
- R8: uipFlag rises in the cycle after the tick that moves the phase to 16376, which is 8 ticks before the strobe. It stays high through the strobe cycle and falls when updateDone is high. A strobe happens only while uipFlag is high.
- R9: While setHold is 1, uipFlag is cleared on the next clock, no strobe is produced, and the chain keeps counting.
- R10: updateStrobe lasts one cycle, and updateDone is high for one cycle in the cycle right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Active-low power-on reset |
| tick | input | 1 | One-cycle enable at 32.768 kHz |
| oscCtl | input | 3 | Oscillator/chain control code |
| rateSel | input | 4 | Rate code choosing the stage |
| sqwEn | input | 1 | Square-wave output enable |
| setHold | input | 1 | Blocks update transfers, clears uipFlag |
| sqwOut | output | 1 | Gated square wave |
| periodicPulse | output | 1 | One-cycle pulse per selected-stage period |
| uipFlag | output | 1 | Update-in-progress status |
| updateStrobe | output | 1 | One-cycle update transfer strobe |
| updateDone | output | 1 | One-cycle pulse after the strobe |

## Verification
The hardest case to reach from the ports is a hold or an oscillator change that lands inside the eight-tick lead window before a strobe. This case decides whether a strobe can still appear while uipFlag is low. The bench tracks the expected chain phase. Whenever that phase nears 16376 to 16384, it raises setHold or leaves code 010 at random, with gaps in tick. This drives many seconds through the window while the chain keeps its true phase.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

  typedef struct packed {
    logic advance;  // count one tick
    logic clear;    // force chain to phase zero
  } chainCmd_t;

  // stage index for a nonzero rate code; codes 1 and 2 alias slow stages
  function automatic int tapIndex(input int rate);
    if (rate == 1) return 6;
    else if (rate == 2) return 7;
    else if (rate >= 3) return rate - 2;
    else return 0;
  endfunction

endpackage

// File: rtl/rtc_div_datapath.sv
module rtc_div_datapath
  import rtc_div_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              porN,
  input  chainCmd_t         cmd,
  input  logic [3:0]        rateSel,
  input  logic              sqwEn,
  output logic [STAGES-1:0] phaseCnt,
  output logic              sqwOut,
  output logic              periodicPulse
);
  localparam int RATES = 16;

  logic [RATES-1:0] tapVec;
  logic             tapBit;
  logic             tapPrev;

  always_ff @(posedge clk) begin
    if (!porN) begin
      phaseCnt <= '0;
      tapPrev  <= 1'b0;
    end else begin
      tapPrev <= tapBit;
      if (cmd.clear) phaseCnt <= '0;
      else if (cmd.advance) phaseCnt <= phaseCnt + 1'b1;
    end
  end

  assign tapVec[0] = 1'b0;
  for (genvar g = 1; g < RATES; g++) begin : g_tap
    assign tapVec[g] = phaseCnt[tapIndex(g)];
  end

  assign tapBit        = tapVec[rateSel];
  assign sqwOut        = sqwEn & tapBit;
  assign periodicPulse = tapBit & ~tapPrev;

  // R6: a held chain is at zero on the next cycle
  p_hold_zero_r6: assert property (@(posedge clk) disable iff (!porN)
    cmd.clear |=> (phaseCnt == '0));
  // R6: without advance or clear the phase does not move
  p_freeze_r6: assert property (@(posedge clk) disable iff (!porN)
    (!cmd.advance && !cmd.clear) |=> $stable(phaseCnt));
  // R5: periodic pulse never lasts two cycles
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!porN)
    periodicPulse |=> !periodicPulse);
endmodule

// File: rtl/rtc_div_control.sv
module rtc_div_control
  import rtc_div_pkg::*;
#(
  parameter int STAGES     = 15,
  parameter int LEAD_TICKS = 8
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              tick,
  input  logic [2:0]        oscCtl,
  input  logic              setHold,
  input  logic [STAGES-1:0] phaseCnt,
  output chainCmd_t         cmd,
  output logic              uipFlag,
  output logic              updateStrobe,
  output logic              updateDone
);
  localparam logic [STAGES-1:0] HALF_PHASE = STAGES'(1) << (STAGES - 1);
  localparam logic [STAGES-1:0] LEAD_PHASE = HALF_PHASE - STAGES'(LEAD_TICKS);

  logic              runMode;
  logic              holdMode;
  logic [STAGES-1:0] nextCnt;
  logic              stepNow;

  assign runMode  = (oscCtl == 3'b010);
  assign holdMode = (oscCtl[2:1] == 2'b11);
  assign stepNow  = runMode & tick;
  assign nextCnt  = phaseCnt + 1'b1;

  always_comb begin
    cmd         = '0;
    cmd.clear   = holdMode;
    cmd.advance = stepNow;
  end

  always_ff @(posedge clk) begin
    if (!porN) begin
      uipFlag      <= 1'b0;
      updateStrobe <= 1'b0;
      updateDone   <= 1'b0;
    end else begin
      updateDone   <= updateStrobe;
      updateStrobe <= stepNow && (nextCnt == HALF_PHASE) && uipFlag && !setHold;
      if (!runMode || setHold) uipFlag <= 1'b0;
      else if (stepNow && nextCnt == LEAD_PHASE) uipFlag <= 1'b1;
      else if (updateStrobe) uipFlag <= 1'b0;
    end
  end

  // R8: a transfer only happens under the in-progress flag
  p_strobe_uip_r8: assert property (@(posedge clk) disable iff (!porN)
    updateStrobe |-> uipFlag);
  // R10: strobe is one cycle and is followed by the done pulse
  p_done_follows_r10: assert property (@(posedge clk) disable iff (!porN)
    updateStrobe |=> (updateDone && !updateStrobe));
  // R9: hold drops the status bit on the next clock
  p_hold_clears_uip_r9: assert property (@(posedge clk) disable iff (!porN)
    setHold |=> !uipFlag);
  // R9: no strobe is issued from a cycle in which hold is set
  p_hold_blocks_r9: assert property (@(posedge clk) disable iff (!porN)
    setHold |=> !updateStrobe);
endmodule

// File: rtl/rtc_divider_timing.sv
module rtc_divider_timing
  import rtc_div_pkg::*;
#(
  parameter int STAGES     = 15,
  parameter int LEAD_TICKS = 8
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       tick,
  input  logic [2:0] oscCtl,
  input  logic [3:0] rateSel,
  input  logic       sqwEn,
  input  logic       setHold,
  output logic       sqwOut,
  output logic       periodicPulse,
  output logic       uipFlag,
  output logic       updateStrobe,
  output logic       updateDone
);
  chainCmd_t         cmd;
  logic [STAGES-1:0] phaseCnt;

  rtc_div_control #(.STAGES(STAGES), .LEAD_TICKS(LEAD_TICKS)) u_ctrl (
    .clk(clk), .porN(porN), .tick(tick), .oscCtl(oscCtl), .setHold(setHold),
    .phaseCnt(phaseCnt), .cmd(cmd), .uipFlag(uipFlag),
    .updateStrobe(updateStrobe), .updateDone(updateDone)
  );

  rtc_div_datapath #(.STAGES(STAGES)) u_dp (
    .clk(clk), .porN(porN), .cmd(cmd), .rateSel(rateSel), .sqwEn(sqwEn),
    .phaseCnt(phaseCnt), .sqwOut(sqwOut), .periodicPulse(periodicPulse)
  );
endmodule

// File: tb/rtc_divider_timing_bench.sv
module rtc_divider_timing_bench;
  logic clk = 1'b0;
  logic porN, tick, sqwEn, setHold;
  logic [2:0] oscCtl;
  logic [3:0] rateSel;
  logic sqwOut, periodicPulse, uipFlag, updateStrobe, updateDone;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rtc_divider_timing u_rtc_divider_timing (
    .clk(clk), .porN(porN), .tick(tick), .oscCtl(oscCtl), .rateSel(rateSel),
    .sqwEn(sqwEn), .setHold(setHold), .sqwOut(sqwOut),
    .periodicPulse(periodicPulse), .uipFlag(uipFlag),
    .updateStrobe(updateStrobe), .updateDone(updateDone)
  );

  // rate code -> frequency in Hz (R2, R3)
  function automatic int freqOf(input int rate);
    case (rate)
      1: return 256;   2: return 128;   3: return 8192;  4: return 4096;
      5: return 2048;  6: return 1024;  7: return 512;   8: return 256;
      9: return 128;   10: return 64;   11: return 32;   12: return 16;
      13: return 8;    14: return 4;    15: return 2;    default: return 0;
    endcase
  endfunction

  function automatic bit expTap(input int cnt, input int rate);
    int f;
    f = freqOf(rate);
    if (f == 0) return 1'b0;
    return ((cnt / (32768 / (2 * f))) % 2) == 1;
  endfunction

  // expected state, advanced from the driven inputs
  int mCnt;
  bit mUip, mUpd, mDone, mTapPrev;

  always @(posedge clk) begin
    int nxt;
    if (!porN) begin
      mCnt = 0; mUip = 0; mUpd = 0; mDone = 0; mTapPrev = 0;
    end else begin
      nxt = (mCnt + 1) % 32768;
      mTapPrev = expTap(mCnt, rateSel);
      mDone = mUpd;
      mUpd = (oscCtl == 3'b010) && tick && (nxt == 16384) && mUip && !setHold;
      if (oscCtl != 3'b010 || setHold) mUip = 0;
      else if (tick && nxt == 16376) mUip = 1;
      else if (mDone) mUip = 0;
      if (oscCtl[2:1] == 2'b11) mCnt = 0;
      else if (oscCtl == 3'b010 && tick) mCnt = nxt;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit tp;
    tp = expTap(mCnt, rateSel);
    check("R2/R3/R4 sqwOut", sqwOut, sqwEn && tp);
    check("R5 periodicPulse", periodicPulse, tp && !mTapPrev);
    check("R8 uipFlag", uipFlag, mUip);
    check("R7 updateStrobe", updateStrobe, mUpd);
    check("R10 updateDone", updateDone, mDone);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int firstUip, firstStrobe, firstDone, pulses;
    void'($urandom(32'd4711));
    porN = 0; tick = 0; oscCtl = 3'b000; rateSel = 4'd0; sqwEn = 0; setHold = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 sqwOut", sqwOut, 0);
    check("R1 periodicPulse", periodicPulse, 0);
    check("R1 uipFlag", uipFlag, 0);
    check("R1 updateStrobe", updateStrobe, 0);
    check("R1 updateDone", updateDone, 0);
    porN = 1; oscCtl = 3'b010; tick = 1; sqwEn = 1; rateSel = 4'd3;

    // phase A: continuous ticks, walk every rate code; first update timing (R7, R8)
    firstUip = 0; firstStrobe = 0; firstDone = 0; pulses = 0;
    for (int cyc = 1; cyc <= 17000; cyc++) begin
      @(negedge clk);
      compareAll();
      if (uipFlag && firstUip == 0) firstUip = cyc;
      if (updateStrobe && firstStrobe == 0) firstStrobe = cyc;
      if (updateDone && firstDone == 0) firstDone = cyc;
      if (rateSel == 4'd0 && periodicPulse) pulses++;
      if (cyc % 1024 == 0) rateSel = 4'((cyc / 1024) % 16);
      sqwEn = ($urandom % 4) != 0;
    end
    check("R8 first uip cycle", firstUip, 16376);
    check("R7 first strobe cycle", firstStrobe, 16384);
    check("R10 first done cycle", firstDone, 16385);
    check("R3 rate zero pulses", pulses, 0);

    // R6: hold code pins chain, stop code freezes it
    oscCtl = 3'b110;
    repeat (3) begin @(negedge clk); compareAll(); end
    rateSel = 4'd3; oscCtl = 3'b001;
    repeat (20) begin @(negedge clk); compareAll(); check("R6 frozen sqw", sqwOut, 0); end
    oscCtl = 3'b010;

    // phase B: random ticks, rates, holds aimed at the lead window
    for (int cyc = 0; cyc < 150000; cyc++) begin
      @(negedge clk);
      compareAll();
      tick = ($urandom % 4) != 0;
      if (cyc % 700 == 0) rateSel = 4'($urandom % 16);
      if (cyc % 97 == 0) sqwEn = $urandom % 2;
      if (mCnt >= 16366 && mCnt <= 16386) begin
        setHold = ($urandom % 8) == 0;
        if ($urandom % 60 == 0) oscCtl = 3'b100;
        else if ($urandom % 200 == 0) oscCtl = 3'b111;
        else oscCtl = 3'b010;
      end else begin
        setHold = ($urandom % 3000) == 0;
        oscCtl = (($urandom % 5000) == 0) ? 3'b110 : 3'b010;
      end
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule